// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Detector

This block compares a reference clock with a feedback clock and tells a downstream charge pump which way to steer. Both clocks arrive as asynchronous levels. They are resynchronised into the system clock domain, and only their rising edges are used, so the duty cycle of either clock has no effect on the result. A rising edge on the reference arms a pump-up request. A rising edge on the feedback arms a pump-down request. When both requests are armed, both are withdrawn on the next system clock. The correction output therefore has three states: drive high, drive low, or high impedance.

When the reference runs faster than the feedback, the block spends its driving time pushing up. When the reference runs slower, it spends that time pulling down. At equal frequency it drives for exactly the phase gap, measured in system clock cycles, in the direction that closes the gap. When the two clocks are aligned, the output stays in high impedance, so the loop filter voltage is held. A lock output is high whenever neither driver is active.

Top module: `phase_freq_detector`

## Requirements
- R1: While `rstN` is low, and after its release with no input edges, `pumpUp` and `pumpDown` are 0 and `outHiZ` and `lockPulse` are 1.
- R2: A rising edge of `refIn` that is first sampled at system clock edge k raises `pumpUp` at edge k+SYNC_STAGES, provided no feedback request is pending.
- R3: With equal periods and `refIn` leading `fbIn` by d system clock cycles, `pumpUp` is high for exactly d cycles per period and `pumpDown` never rises.
- R4: With equal periods and `fbIn` leading `refIn` by d cycles, `pumpDown` is high for exactly d cycles per period and `pumpUp` never rises.
- R5: When both inputs rise in the same system clock cycle, neither driver becomes active and `lockPulse` stays high.
- R6: When the reference period is shorter than the feedback period, `pumpDown` never rises and `pumpUp` does rise.
- R7: When the reference period is longer than the feedback period, `pumpUp` never rises and `pumpDown` does rise.
- R8: Only rising edges count. Changing the high time of either input, with its rising edges unchanged, leaves the number of driving cycles unchanged.
- R9: `pumpUp` and `pumpDown` are never high together. When both internal requests are armed, both are cleared on the next system clock, unless a new rising edge re-arms one of them.
- R10: `outHiZ` is 1 exactly when neither `pumpUp` nor `pumpDown` is 1, and `lockPulse` always equals `outHiZ`.
- R11: An armed request holds with no time limit until an edge arrives on the opposite input. With `fbIn` idle, `pumpUp` stays high from the first detected reference edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both compared clocks |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | Reference clock, asynchronous level |
| fbIn | input | 1 | Feedback clock, asynchronous level |
| pumpUp | output | 1 | Drive-high request to the charge pump |
| pumpDown | output | 1 | Drive-low request to the charge pump |
| outHiZ | output | 1 | High when the correction output is high impedance |
| lockPulse | output | 1 | Phase-pulse lock indication, high while neither driver is active |

## Verification
The bench builds the block with SYNC_STAGES = 2, which makes the edge-to-output latency three system cycles. That latency is short enough to sweep every phase offset d from 1 to P-2 for several small periods P, in both directions and with aligned edges. With such short periods, mismatched frequencies produce coincident edges and clear-cycle collisions within a few hundred cycles, so both the rule that clearing takes priority and the re-arm path are exercised. The same arithmetic model, d driving cycles per period, also covers the duty-cycle sweep and the idle-feedback hold case.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;

  // Strobes from control to the flag datapath, valid for one system cycle.
  typedef struct packed {
    logic refRise;    // reference rising edge detected
    logic fbRise;     // feedback rising edge detected
    logic clearBoth;  // both requests armed: withdraw them
  } pfdStrobe_t;

  localparam int NUM_CH = 2;
  localparam int CH_REF = 0;
  localparam int CH_FB  = 1;

endpackage

// File: rtl/pfd_sync_edge.sv
`timescale 1ns/1ps
module pfd_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseStb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain;
  logic          prevLevel;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[LAST-1:0], asyncIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= chain[LAST];
  end

  assign riseStb = chain[LAST] & ~prevLevel;

  // R8: a level change yields a single one-cycle strobe, so high time cannot add strobes
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |=> !riseStb);

endmodule

// File: rtl/pfd_ctrl.sv
`timescale 1ns/1ps
module pfd_ctrl
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refIn,
  input  logic       fbIn,
  input  logic       bothSet,
  output pfdStrobe_t strb
);

  logic [NUM_CH-1:0] chanIn;
  logic [NUM_CH-1:0] chanRise;

  assign chanIn[CH_REF] = refIn;
  assign chanIn[CH_FB]  = fbIn;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      pfd_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rstN    (rstN),
        .asyncIn (chanIn[ch]),
        .riseStb (chanRise[ch])
      );
    end
  endgenerate

  always_comb begin
    strb.refRise   = chanRise[CH_REF];
    strb.fbRise    = chanRise[CH_FB];
    strb.clearBoth = bothSet;
  end

endmodule

// File: rtl/pfd_datapath.sv
`timescale 1ns/1ps
module pfd_datapath
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pfdStrobe_t strb,
  output logic       bothSet,
  output logic       pumpUp,
  output logic       pumpDown,
  output logic       outHiZ,
  output logic       lockPulse
);

  logic upFlag;
  logic downFlag;

  // Clearing takes priority over holding, and a fresh edge re-arms its own flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upFlag   <= 1'b0;
      downFlag <= 1'b0;
    end else begin
      upFlag   <= (strb.clearBoth ? 1'b0 : upFlag)   | strb.refRise;
      downFlag <= (strb.clearBoth ? 1'b0 : downFlag) | strb.fbRise;
    end
  end

  assign bothSet  = upFlag & downFlag;
  assign pumpUp   = upFlag & ~downFlag;
  assign pumpDown = downFlag & ~upFlag;

  always_comb begin
    outHiZ    = ~(pumpUp | pumpDown);
    lockPulse = outHiZ;
  end

  // R2: a detected reference edge arms the up request on the next cycle
  a_r2_ref_arms: assert property (@(posedge clk) disable iff (!rstN)
    strb.refRise |=> upFlag);

  a_r2_fb_arms: assert property (@(posedge clk) disable iff (!rstN)
    strb.fbRise |=> downFlag);

  // R9: both armed with no new edge means both withdrawn one cycle later
  a_r9_clear_both: assert property (@(posedge clk) disable iff (!rstN)
    (upFlag && downFlag && !strb.refRise && !strb.fbRise) |=> (!upFlag && !downFlag));

  // R11: a lone request holds until the opposite edge arrives
  a_r11_hold_up: assert property (@(posedge clk) disable iff (!rstN)
    (upFlag && !downFlag) |=> upFlag);

  a_r11_hold_down: assert property (@(posedge clk) disable iff (!rstN)
    (downFlag && !upFlag) |=> downFlag);

endmodule

// File: rtl/phase_freq_detector.sv
`timescale 1ns/1ps
module phase_freq_detector
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  input  logic fbIn,
  output logic pumpUp,
  output logic pumpDown,
  output logic outHiZ,
  output logic lockPulse
);

  pfdStrobe_t strb;
  logic       bothSet;

  pfd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .refIn   (refIn),
    .fbIn    (fbIn),
    .bothSet (bothSet),
    .strb    (strb)
  );

  pfd_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bothSet   (bothSet),
    .pumpUp    (pumpUp),
    .pumpDown  (pumpDown),
    .outHiZ    (outHiZ),
    .lockPulse (lockPulse)
  );

  // R1: first cycle after reset release shows an idle, locked output
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!pumpUp && !pumpDown && lockPulse && outHiZ));

  // R10: any active driver pulls the lock indication and high-impedance flag low
  a_r10_lock_low_when_driving: assert property (@(posedge clk) disable iff (!rstN)
    (pumpUp || pumpDown) |-> (!lockPulse && !outHiZ));

endmodule

// File: tb/phase_freq_detector_tb.sv
`timescale 1ns/1ps
module phase_freq_detector_tb;

  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;   // iterations from drive to visible output

  logic clk = 1'b0;
  logic rstN;
  logic refIn;
  logic fbIn;
  logic pumpUp, pumpDown, outHiZ, lockPulse;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  phase_freq_detector #(.SYNC_STAGES(SYNC)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .refIn     (refIn),
    .fbIn      (fbIn),
    .pumpUp    (pumpUp),
    .pumpDown  (pumpDown),
    .outHiZ    (outHiZ),
    .lockPulse (lockPulse)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN  = 1'b0;
    refIn = 1'b0;
    fbIn  = 1'b0;
    repeat (3) @(negedge clk);
    check(!pumpUp && !pumpDown && outHiZ && lockPulse, "R1", "outputs in reset",
          {pumpUp, pumpDown, outHiZ, lockPulse}, 4'b0011);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!pumpUp && !pumpDown && outHiZ && lockPulse, "R1", "outputs after release",
          {pumpUp, pumpDown, outHiZ, lockPulse}, 4'b0011);
  endtask

  // Drives periodic waves, counting driving cycles and rule violations.
  task automatic runWave(input int pRef, input int pFb, input int offRef, input int offFb,
                         input int hiRef, input int hiFb, input int len, input int tail,
                         input bit fbOn,
                         output int upCnt, output int dnCnt,
                         output int bothCnt, output int lockBad);
    upCnt = 0; dnCnt = 0; bothCnt = 0; lockBad = 0;
    for (int cyc = 0; cyc < len + tail; cyc++) begin
      @(negedge clk);
      if (pumpUp)   upCnt++;
      if (pumpDown) dnCnt++;
      if (pumpUp && pumpDown) bothCnt++;
      if ((outHiZ !== !(pumpUp || pumpDown)) || (lockPulse !== outHiZ)) lockBad++;
      refIn = (cyc < len && cyc >= offRef) ? (((cyc - offRef) % pRef) < hiRef) : 1'b0;
      fbIn  = (fbOn && cyc < len && cyc >= offFb) ? (((cyc - offFb) % pFb) < hiFb) : 1'b0;
    end
  endtask

  initial begin
    int up, dn, both, lb;

    doReset();

    // R2: latency from first sampled reference edge to pumpUp
    @(negedge clk); refIn = 1'b1;
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      check(pumpUp == (k == LAT), "R2", $sformatf("pumpUp at +%0d", k),
            pumpUp, (k == LAT));
    end

    // R3 and R4: equal periods, phase sweep in both directions
    for (int p = 4; p <= 9; p += 2) begin
      for (int d = 1; d <= p - 2; d++) begin
        doReset();
        runWave(p, p, 1, 1 + d, p / 2, p / 2, 5 * p, 8, 1'b1, up, dn, both, lb);
        check(up == 5 * d, "R3", $sformatf("up cycles p=%0d d=%0d", p, d), up, 5 * d);
        check(dn == 0, "R3", "down cycles", dn, 0);
        check(both == 0 && lb == 0, "R9", "exclusive/lock", both + lb, 0);
        doReset();
        runWave(p, p, 1 + d, 1, p / 2, p / 2, 5 * p, 8, 1'b1, up, dn, both, lb);
        check(dn == 5 * d, "R4", $sformatf("down cycles p=%0d d=%0d", p, d), dn, 5 * d);
        check(up == 0, "R4", "up cycles", up, 0);
        check(lb == 0, "R10", "lock/hiZ mismatch", lb, 0);
      end
    end

    // R5: coincident edges
    for (int p = 3; p <= 8; p++) begin
      doReset();
      runWave(p, p, 1, 1, 1, p - 1, 6 * p, 8, 1'b1, up, dn, both, lb);
      check(up + dn == 0, "R5", $sformatf("driving cycles p=%0d", p), up + dn, 0);
    end

    // R8: duty cycle sweep, rising edges fixed
    for (int h = 1; h <= 7; h++) begin
      doReset();
      runWave(8, 8, 1, 4, h, 8 - h, 40, 8, 1'b1, up, dn, both, lb);
      check(up == 15 && dn == 0, "R8", $sformatf("up cycles high=%0d", h), up, 15);
    end

    // R6 and R7: unequal frequencies
    for (int s = 0; s < 3; s++) begin
      int fast, slow;
      fast = (s == 0) ? 7 : (s == 1) ? 5 : 4;
      slow = (s == 0) ? 9 : (s == 1) ? 6 : 11;
      doReset();
      runWave(fast, slow, 1, 2, fast / 2, slow / 2, 200, 8, 1'b1, up, dn, both, lb);
      check(dn == 0, "R6", $sformatf("down cycles %0d/%0d", fast, slow), dn, 0);
      check(up > 0, "R6", "up cycles present", up, 1);
      check(both == 0, "R9", "both high", both, 0);
      doReset();
      runWave(slow, fast, 2, 1, slow / 2, fast / 2, 200, 8, 1'b1, up, dn, both, lb);
      check(up == 0, "R7", $sformatf("up cycles %0d/%0d", slow, fast), up, 0);
      check(dn > 0, "R7", "down cycles present", dn, 1);
      check(lb == 0, "R10", "lock/hiZ mismatch", lb, 0);
    end

    // R11: feedback idle, up holds from first detected edge
    doReset();
    runWave(5, 5, 1, 0, 2, 2, 40, 0, 1'b0, up, dn, both, lb);
    check(up == 40 - (1 + LAT), "R11", "continuous up cycles", up, 40 - (1 + LAT));
    check(dn == 0, "R11", "down cycles", dn, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule